// File: doc/BRIEF.md
# Bitplane to Raster Pixel Serializer

This block sits between the display-memory read path and the palette lookup in a raster video pipeline. Each pixel clock it receives one byte fetched from display memory and the horizontal coordinate of the pixel being drawn. From these it extracts the bits that belong to that pixel and emits a palette index. The byte may hold eight 1-bit pixels, four 2-bit pixels, two 4-bit pixels or one 8-bit pixel.

The low bits of the coordinate choose the field inside the byte, and the leftmost pixel always comes from the most significant end. In the 1-bit mode a set bit selects a foreground colour input and a clear bit selects a background colour input. Field selection uses the coordinate presented in the same cycle as the byte. The result is registered once, so the output always lags the inputs by exactly one clock. This lets upstream address and coordinate pipelines be sized with a single known offset.

A pixel-enable input travels with the data. Where it is low, for example during blanking, the output is zero one clock later.

Top module: `bitplane_raster`

## Requirements
- R1: While rst_ni is low the pixel output is 0.
- R2: The output in the cycle after a clock edge is computed only from the x, data, mode, colour and enable values sampled at that edge. The latency is exactly one clock, and no earlier cycle's x is used.
- R3: Mode code 0 (one bit per pixel) shows data bit 7 minus x[2:0], so x=0 shows bit 7. A 1 in that bit gives fg_i and a 0 gives bg_i.
- R4: Mode code 1 (two bits per pixel) outputs a zero-extended 2-bit field. x[2:1]=0 gives bits 7:6, 1 gives bits 5:4, 2 gives bits 3:2 and 3 gives bits 1:0.
- R5: Mode code 2 (four bits per pixel) outputs a zero-extended nibble. x[2]=0 gives bits 7:4 and x[2]=1 gives bits 3:0.
- R6: Mode code 3 (eight bits per pixel) outputs the whole data byte as the index.
- R7: Mode codes 4 to 7 output bg_i.
- R8: When pix_en_i is low at an edge, the output after that edge is 0 whatever the other inputs are.
- R9: x bits above bit 2 have no effect on the selected field in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 12 | Horizontal pixel coordinate of the current byte |
| data_i | input | 8 | Byte read from display memory |
| mode_i | input | 3 | Packing mode code |
| fg_i | input | 8 | Foreground index for set bits in 1-bit mode |
| bg_i | input | 8 | Background index for clear bits and for unused modes |
| pix_en_i | input | 1 | Pixel enable, aligned with data_i |
| pix_o | output | 8 | Registered palette index |

## Verification
The bench drives a continuous stream in which x and data change every cycle. A design that selected fields with a registered copy of x would then show the neighbouring pixel's field, and a design with an extra stage would lag by one pixel. Every x position is walked in each mode with asymmetric byte patterns. This exposes a reversed bit order and a nibble selected by x[3] instead of x[2], which would repeat each nibble across eight pixels. High x bits are toggled to show they are ignored. Unused mode codes and a low enable are checked for the background colour and zero respectively, so a design that passes data through in those cases is caught.

// File: rtl/bitplane_raster_pkg.sv
package bitplane_raster_pkg;
  localparam int MODE_W = 3;
  typedef enum logic [MODE_W-1:0] {
    MODE_1BPP = 3'd0,
    MODE_2BPP = 3'd1,
    MODE_4BPP = 3'd2,
    MODE_8BPP = 3'd3
  } pix_mode_e;
endpackage

// File: rtl/bitplane_raster_field_sel.sv
// Extracts, for every field width 2**k, the field addressed by x (MSB first).
module bitplane_raster_field_sel #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8,
  parameter int SEL_W  = $clog2(DATA_W)
) (
  input  logic [SEL_W-1:0]  xsel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [IDX_W-1:0]  fld_o [SEL_W+1]
);
  for (genvar k = 0; k <= SEL_W; k++) begin : g_width
    localparam int BPP = 1 << k;
    if (k == SEL_W) begin : g_full
      assign fld_o[k] = IDX_W'(data_i);
    end else begin : g_part
      logic [SEL_W-k-1:0] pos;
      logic [DATA_W-1:0]  sh;
      assign pos      = ~xsel_i[SEL_W-1:k];  // leftmost pixel in top field
      assign sh       = data_i >> (SEL_W'(pos) << k);
      assign fld_o[k] = IDX_W'(sh[BPP-1:0]);
    end
  end
endmodule

// File: rtl/bitplane_raster_mode_mux.sv
module bitplane_raster_mode_mux
  import bitplane_raster_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int SEL_W = 3
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [IDX_W-1:0]  fld_i [SEL_W+1],
  input  logic [IDX_W-1:0]  fg_i,
  input  logic [IDX_W-1:0]  bg_i,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    idx_o = bg_i;
    if (mode_i == MODE_1BPP) begin
      idx_o = fld_i[0][0] ? fg_i : bg_i;
    end else begin
      for (int k = 1; k <= SEL_W; k++) begin
        if (int'(mode_i) == k) idx_o = fld_i[k];
      end
    end
  end
endmodule

// File: rtl/bitplane_raster_out_reg.sv
module bitplane_raster_out_reg #(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] pix_o
);
  logic             en_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      en_q  <= en_i;
      idx_q <= idx_i;
    end
  end

  assign pix_o = en_q ? idx_q : '0;
endmodule

// File: rtl/bitplane_raster.sv
module bitplane_raster
  import bitplane_raster_pkg::*;
#(
  parameter int X_W    = 12,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [X_W-1:0]    x_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [IDX_W-1:0]  fg_i,
  input  logic [IDX_W-1:0]  bg_i,
  input  logic              pix_en_i,
  output logic [IDX_W-1:0]  pix_o
);
  localparam int SEL_W = $clog2(DATA_W);

  logic [IDX_W-1:0] fld [SEL_W+1];
  logic [IDX_W-1:0] idx;

  // same-cycle x: no register ahead of selection
  bitplane_raster_field_sel #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_sel (
    .xsel_i (x_i[SEL_W-1:0]),
    .data_i (data_i),
    .fld_o  (fld)
  );

  bitplane_raster_mode_mux #(.IDX_W(IDX_W), .SEL_W(SEL_W)) u_mux (
    .mode_i (mode_i),
    .fld_i  (fld),
    .fg_i   (fg_i),
    .bg_i   (bg_i),
    .idx_o  (idx)
  );

  bitplane_raster_out_reg #(.IDX_W(IDX_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (pix_en_i),
    .idx_i  (idx),
    .pix_o  (pix_o)
  );
endmodule

// File: rtl/bitplane_raster_chk.sv
module bitplane_raster_chk
  import bitplane_raster_pkg::*;
#(
  parameter int X_W    = 12,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [X_W-1:0]    x_i,
  input logic [DATA_W-1:0] data_i,
  input logic [MODE_W-1:0] mode_i,
  input logic [IDX_W-1:0]  fg_i,
  input logic [IDX_W-1:0]  bg_i,
  input logic              pix_en_i,
  input logic [IDX_W-1:0]  pix_o
);
  localparam int SEL_W = $clog2(DATA_W);

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  logic mono_bit;
  assign mono_bit = data_i[DATA_W-1-int'(x_i[SEL_W-1:0])];

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> pix_o == '0);

  assert_enable_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$past(pix_en_i) |-> pix_o == '0);

  assert_mono_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(pix_en_i) && $past(mode_i) == MODE_1BPP
      |-> pix_o == ($past(mono_bit) ? $past(fg_i) : $past(bg_i)));

  assert_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(pix_en_i) && $past(mode_i) == MODE_8BPP
      |-> pix_o == IDX_W'($past(data_i)));

  assert_unused_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(pix_en_i) && int'($past(mode_i)) > SEL_W
      |-> pix_o == $past(bg_i));
endmodule

bind bitplane_raster bitplane_raster_chk #(.X_W(X_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_bitplane_raster.sv
`timescale 1ns/1ps
module tb_bitplane_raster;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] x_i = '0;
  logic [7:0]  data_i = '0;
  logic [2:0]  mode_i = '0;
  logic [7:0]  fg_i = '0;
  logic [7:0]  bg_i = '0;
  logic        pix_en_i = 1'b0;
  logic [7:0]  pix_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk_i = ~clk_i;

  bitplane_raster dut (.*);

  function automatic logic [7:0] model(input logic [11:0] x, input logic [7:0] d,
                                       input logic [2:0] m, input logic [7:0] fg,
                                       input logic [7:0] bg, input logic en);
    int p;
    p = int'(x[2:0]);
    if (!en) return 8'h00;
    case (m)
      3'd0: return d[7-p] ? fg : bg;
      3'd1: return {6'b0, d[7-2*(p/2) -: 2]};
      3'd2: return {4'b0, (p >= 4) ? d[3:0] : d[7:4]};
      3'd3: return d;
      default: return bg;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pix_o=%02h expected %02h", req, act, exp);
    end
  endtask

  // drive at negedge, sample one edge later
  task automatic step(input string req, input logic [11:0] x, input logic [7:0] d,
                      input logic [2:0] m, input logic [7:0] fg, input logic [7:0] bg,
                      input logic en);
    logic [7:0] e;
    @(negedge clk_i);
    x_i = x; data_i = d; mode_i = m; fg_i = fg; bg_i = bg; pix_en_i = en;
    e = model(x, d, m, fg, bg, en);
    @(posedge clk_i);
    #1 check(req, pix_o, e);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    x_i = 12'd5; data_i = 8'hff; mode_i = 3'd3; pix_en_i = 1'b1;
    @(posedge clk_i); #1 check("R1", pix_o, 8'h00);
    @(posedge clk_i); #1 check("R1", pix_o, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_mono();
    for (int x = 0; x < 8; x++) step("R3", 12'(x), 8'b1011_0010, 3'd0, 8'hc5, 8'h3a, 1'b1);
    for (int x = 0; x < 8; x++) step("R3", 12'(x), 8'b0100_1101, 3'd0, 8'h11, 8'hee, 1'b1);
  endtask

  task automatic t_2bpp();
    for (int x = 0; x < 8; x++) step("R4", 12'(x), 8'b00_01_10_11, 3'd1, 8'h55, 8'h66, 1'b1);
    for (int x = 0; x < 8; x++) step("R4", 12'(x), 8'b10_11_00_01, 3'd1, 8'h55, 8'h66, 1'b1);
  endtask

  task automatic t_4bpp();
    for (int x = 0; x < 16; x++) step("R5", 12'(x), 8'h3c, 3'd2, 8'h00, 8'h99, 1'b1);
  endtask

  task automatic t_8bpp();
    step("R6", 12'd0, 8'ha7, 3'd3, 8'h01, 8'h02, 1'b1);
    step("R6", 12'd7, 8'h00, 3'd3, 8'h01, 8'h02, 1'b1);
    step("R6", 12'd3, 8'hff, 3'd3, 8'h01, 8'h02, 1'b1);
  endtask

  task automatic t_unused();
    for (int m = 4; m < 8; m++) step("R7", 12'(m), 8'hf0, 3'(m), 8'haa, 8'h4b, 1'b1);
  endtask

  task automatic t_enable();
    step("R8", 12'd0, 8'hff, 3'd0, 8'h77, 8'h88, 1'b0);
    step("R8", 12'd2, 8'h5a, 3'd3, 8'h77, 8'h88, 1'b0);
    step("R8", 12'd1, 8'h5a, 3'd6, 8'h77, 8'h88, 1'b0);
    step("R8", 12'd1, 8'h5a, 3'd3, 8'h77, 8'h88, 1'b1);
  endtask

  task automatic t_high_x();
    for (int h = 0; h < 4; h++) begin
      step("R9", {7'(h * 37), 5'b01010}, 8'b1001_0110, 3'd0, 8'h21, 8'h12, 1'b1);
      step("R9", {7'(h * 11), 5'b11101}, 8'b1001_0110, 3'd1, 8'h21, 8'h12, 1'b1);
      step("R9", {7'(h * 5),  5'b01011}, 8'h6d,        3'd2, 8'h21, 8'h12, 1'b1);
    end
  endtask

  // back-to-back stream: x and data change every cycle
  task automatic t_stream();
    for (int i = 0; i < 96; i++) begin
      step("R2", 12'(i * 3 + 1), 8'(i * 73 + 29), 3'(i % 5), 8'(i + 8'h40),
           8'(8'hb0 - i), (i % 7) != 3);
    end
  endtask

  initial begin
    t_reset();
    t_mono();
    t_2bpp();
    t_4bpp();
    t_8bpp();
    t_unused();
    t_enable();
    t_high_x();
    t_stream();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule